// File: doc/BRIEF.md
# Multi-Rail Supervisor Reset Generator

This block drives one active-low processor reset from six supply-good flags and an active-low push-button reset. Each supply flag must stay at a new level for a fixed number of slow-clock cycles before the block acts on it. Flags that dip for less time than that are ignored. The push-button input goes through a two-flop synchronizer. It gates a debounce timer, and that timer's terminal count clears the output register asynchronously. The reset therefore falls within three clocks of a button press. After the button is released, the reset stays low for a full debounce period.

A release-mode pin selects when the reset lets go:

- **Mode pin low:** the reset follows the combined good condition one clock after that condition is registered.
- **Mode pin high:** the reset waits for a stretch timer. The stretch timer runs only while every input is good, and it starts over whenever any input drops.

All timing runs from one slow clock of about 250 kHz. The filter length and both timer periods are parameters, so a bench can shorten them.

Top module: `rail_supervisor`

## Requirements
- R1: While `rst_n` is low, `cpu_rst_n_o` is low.
- R2: A supply flag that stays low for at least FILTER_CYCLES consecutive clocks drives `cpu_rst_n_o` low after exactly FILTER_CYCLES+2 rising clock edges, in either release mode.
- R3: A supply flag that goes low for fewer than FILTER_CYCLES consecutive clocks leaves `cpu_rst_n_o` high.
- R4: When `man_rst_n_i` goes low, `cpu_rst_n_o` is low after at most 3 rising edges. It stays low while the input stays low.
- R5: With `stretch_en_i` = 0 and all supplies good, `cpu_rst_n_o` rises on the DEBOUNCE_CYCLES+3 rising edge after `man_rst_n_i` returns high. It is still low after DEBOUNCE_CYCLES+2 edges. The same timing applies after `rst_n` is released.
- R6: With `stretch_en_i` = 0, `cpu_rst_n_o` rises on the FILTER_CYCLES+2 rising edge after the last low supply flag returns high.
- R7: With `stretch_en_i` = 1, `cpu_rst_n_o` rises on the FILTER_CYCLES+2+STRETCH_CYCLES rising edge after the last low supply flag returns high. It is never high while the stretch timer has not expired.
- R8: With `stretch_en_i` = 1, if any supply drops long enough to pass its filter while the stretch timer is running, the stretch period restarts. The full R7 delay is then counted from that supply's recovery.
- R9: With `stretch_en_i` = 1 and STRETCH_CYCLES > DEBOUNCE_CYCLES, `cpu_rst_n_o` rises on the STRETCH_CYCLES+4 rising edge after `man_rst_n_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow supervisor clock, about 250 kHz |
| rst_n | input | 1 | Active-low power-on reset of all state |
| rail_ok_i | input | NUM_RAILS | Supply-good flags, 1 means the rail is in range |
| man_rst_n_i | input | 1 | Active-low push-button reset, asynchronous |
| stretch_en_i | input | 1 | Release mode: 0 immediate, 1 wait for stretch timer |
| cpu_rst_n_o | output | 1 | Active-low processor reset |

## Verification
The assertions check three relationships on every cycle:

- A low combined-good register forces the output low on the next edge.
- The output is never high while the debounce count is incomplete.
- In stretch mode, the output never releases before the stretch terminal count.

Exact release latencies can only be shown by the bench scenarios. These cover the filter length, the two-flop synchronizer plus debounce delay, the restart of the stretch timer after a mid-period dropout, and the rejection of randomly placed short supply glitches. Each is measured to the exact edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        REL_DIRECT  = 1'b0,
        REL_STRETCH = 1'b1
    } release_mode_e;

    // Counter width able to hold values 0 .. n.
    function automatic int cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    // Reset value 0: treat the button as pressed until sampled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
    parameter int unsigned STABLE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = sup_pkg::cnt_w(STABLE);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(STABLE - 1)) begin
            st_d.lvl = raw_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    // Rails count as bad until proven good.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
endmodule

// File: rtl/sup_gate_timer.sv
module sup_gate_timer #(
    parameter int unsigned PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic tc_o
);
    localparam int CW = sup_pkg::cnt_w(PERIOD);

    typedef struct packed {
        logic          tc;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!gate_i) begin
            st_d = '0;
        end else if (!st_q.tc) begin
            if (st_q.cnt == CW'(PERIOD - 1)) begin
                st_d.tc  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc_o = st_q.tc;
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
    parameter int unsigned NUM_RAILS       = 6,
    parameter int unsigned FILTER_CYCLES   = 12,
    parameter int unsigned STRETCH_CYCLES  = 53248,
    parameter int unsigned DEBOUNCE_CYCLES = 12288
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_ok_i,
    input  logic                 man_rst_n_i,
    input  logic                 stretch_en_i,
    output logic                 cpu_rst_n_o
);
    import sup_pkg::*;

    localparam logic [NUM_RAILS-1:0] ALL_GOOD = {NUM_RAILS{1'b1}};

    typedef struct packed {
        logic gate;
    } top_st_t;

    logic [NUM_RAILS-1:0] rail_filt;
    logic                 man_sync;
    logic                 deb_tc;
    logic                 str_tc;
    logic                 gate_q;
    logic                 clr_n;
    logic                 out_d, out_q;
    release_mode_e        mode;
    top_st_t              st_d, st_q;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        sup_glitch_filter #(.STABLE(FILTER_CYCLES)) i_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (rail_ok_i[g]),
            .level_o (rail_filt[g])
        );
    end

    sup_sync2 i_man_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (man_rst_n_i),
        .sync_o  (man_sync)
    );

    sup_gate_timer #(.PERIOD(DEBOUNCE_CYCLES)) i_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (man_sync),
        .tc_o   (deb_tc)
    );

    sup_gate_timer #(.PERIOD(STRETCH_CYCLES)) i_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_q),
        .tc_o   (str_tc)
    );

    assign gate_q = st_q.gate;
    assign mode   = release_mode_e'(stretch_en_i);

    always_comb begin
        st_d      = st_q;
        st_d.gate = (rail_filt == ALL_GOOD) && man_sync;
        if (mode == REL_STRETCH) out_d = str_tc & gate_q;
        else                     out_d = gate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Output flop is cleared while the debounce count is incomplete.
    assign clr_n = rst_n & deb_tc;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign cpu_rst_n_o = out_q;
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
    input logic clk,
    input logic rst_n,
    input logic gate_q,
    input logic deb_tc,
    input logic str_tc,
    input logic stretch_en_i,
    input logic cpu_rst_n_o
);
    // R2
    gate_low_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> !cpu_rst_n_o);

    // R4
    debounce_clears_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deb_tc |-> !cpu_rst_n_o);

    // R5
    debounce_blocks_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deb_tc |=> !cpu_rst_n_o);

    // R7
    stretch_blocks_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_en_i && !str_tc) |=> !cpu_rst_n_o);
endmodule

bind rail_supervisor sup_checker i_sup_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_q       (gate_q),
    .deb_tc       (deb_tc),
    .str_tc       (str_tc),
    .stretch_en_i (stretch_en_i),
    .cpu_rst_n_o  (cpu_rst_n_o)
);

// File: tb/test_rail_supervisor.sv
module test_rail_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int NR  = 6;
    localparam int FC  = 4;
    localparam int STR = 40;
    localparam int DEB = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rails = '1;
    logic          man_n = 1'b1;
    logic          stretch = 1'b0;
    logic          cpu_rst_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rail_supervisor #(
        .NUM_RAILS(NR), .FILTER_CYCLES(FC),
        .STRETCH_CYCLES(STR), .DEBOUNCE_CYCLES(DEB)
    ) i_rail_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_ok_i    (rails),
        .man_rst_n_i  (man_n),
        .stretch_en_i (stretch),
        .cpu_rst_n_o  (cpu_rst_n)
    );

    function automatic int rail_rise_lat(input bit str_mode);
        return str_mode ? FC + 2 + STR : FC + 2;
    endfunction

    function automatic int man_rise_lat(input bit str_mode);
        return str_mode ? STR + 4 : DEB + 3;
    endfunction

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Output low after lat-1 edges, high after lat edges.
    task automatic check_rise(input string req, input int lat);
        tick(lat - 1);
        chk({req, " still low"}, cpu_rst_n, 1'b0);
        tick(1);
        chk({req, " released"}, cpu_rst_n, 1'b1);
    endtask

    task automatic check_fall(input string req);
        tick(FC + 1);
        chk({req, " not yet low"}, cpu_rst_n, 1'b1);
        tick(1);
        chk({req, " low"}, cpu_rst_n, 1'b0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 reset state
        tick(3);
        chk("R1 reset holds output low", cpu_rst_n, 1'b0);
        rst_n = 1'b1;
        // R5 power-up release follows the debounce timing
        check_rise("R5 power-up", man_rise_lat(1'b0));

        // R4 push-button press
        man_n = 1'b0;
        tick(2);
        chk("R4 before sync", cpu_rst_n, 1'b1);
        tick(1);
        chk("R4 press within 3 edges", cpu_rst_n, 1'b0);
        tick(6);
        chk("R4 held while pressed", cpu_rst_n, 1'b0);
        man_n = 1'b1;
        check_rise("R5 button release", man_rise_lat(1'b0));

        // R4/R5 minimum-width press
        man_n = 1'b0;
        tick(3);
        chk("R4 short press", cpu_rst_n, 1'b0);
        man_n = 1'b1;
        check_rise("R5 short press release", man_rise_lat(1'b0));

        // R2 / R6 rail dropout, immediate mode
        rails[2] = 1'b0;
        check_fall("R2 rail2 drop");
        rails[2] = 1'b1;
        check_rise("R6 rail2 recover", rail_rise_lat(1'b0));

        // R3 random short glitches
        for (int i = 0; i < 24; i++) begin
            int r, len, gap;
            bit ok;
            r   = int'($urandom_range(NR - 1, 0));
            len = int'($urandom_range(FC - 1, 1));
            gap = int'($urandom_range(4, 1));
            ok  = 1'b1;
            rails[r] = 1'b0;
            for (int k = 0; k < len; k++) begin
                tick(1);
                if (cpu_rst_n !== 1'b1) ok = 1'b0;
            end
            rails[r] = 1'b1;
            for (int k = 0; k < gap; k++) begin
                tick(1);
                if (cpu_rst_n !== 1'b1) ok = 1'b0;
            end
            chk("R3 short glitch ignored", ok, 1'b1);
        end
        tick(FC + 2);
        chk("R3 output high after glitches", cpu_rst_n, 1'b1);

        // R7 stretch mode
        tick(STR + 2);
        stretch = 1'b1;
        tick(2);
        rails[0] = 1'b0;
        check_fall("R2 rail0 drop stretch mode");
        tick(1);
        rails[0] = 1'b1;
        check_rise("R7 stretched release", rail_rise_lat(1'b1));

        // R8 restart on mid-period dropout
        rails[1] = 1'b0;
        tick(FC + 3);
        rails[1] = 1'b1;
        tick(STR / 2);
        rails[4] = 1'b0;
        tick(FC);
        rails[4] = 1'b1;
        check_rise("R8 stretch restarted", rail_rise_lat(1'b1));

        // R9 button in stretch mode
        man_n = 1'b0;
        tick(4);
        chk("R4 press in stretch mode", cpu_rst_n, 1'b0);
        man_n = 1'b1;
        check_rise("R9 stretched button release", man_rise_lat(1'b1));

        // Random dropouts in random modes
        for (int i = 0; i < 8; i++) begin
            int r, extra;
            bit m;
            tick(STR + 2);
            m       = 1'(($urandom() % 2));
            stretch = m;
            tick(2);
            r     = int'($urandom_range(NR - 1, 0));
            extra = int'($urandom_range(3, 0));
            rails[r] = 1'b0;
            check_fall(m ? "R2 random drop stretch" : "R2 random drop direct");
            tick(extra);
            rails[r] = 1'b1;
            check_rise(m ? "R7 random recover" : "R6 random recover", rail_rise_lat(m));
        end

        done = 1'b1;
        summary();
    end
endmodule